// File: doc/BRIEF.md
# Translation Configuration Decoder

This block turns one stream table entry, already fetched by the caller, into the parameter set that a page-table walker needs for a single translation stage. If the entry cannot be used, it returns a fault code instead. The parameter set holds the stage number, the granule size in address bits, the input-size field, the table base, the output address size, the 64-bit format flag and the starting lookup level. An entry marked for bypass produces a bypass result with no parameters. A request made while the unit is switched off produces a disabled result.

A stage-2 entry carries everything in its own words, so it resolves two cycles after the start strobe. A stage-1 entry points at a 64-byte context descriptor. The block issues one request on its memory port, waits for the response and then decodes the descriptor. The parameters come from one of the descriptor's two table slots. Every result is reported by a one-cycle `done` pulse, with all outputs registered. The implemented output size and the set of supported stage-2 granules are parameters.

Top module: `xcd_top`

## Requirements
- R1: When `unit_en` is low at the start strobe, the result is `kind`=2 (disabled) with `fault`=0, and no memory request is issued.
- R2: When entry word0 bit 0 (valid) is clear, the result is `fault`=2 (bad entry). On any fault, `kind`, `stage`, `ttb`, `oas`, `gran_bits`, `tsz`, `fmt64` and `level` are zero.
- R3: Entry word0 bits [3:1] select the mode. Value 4 gives `kind`=1 (bypass) with `fault`=0. Value 5 selects stage 1 and value 6 selects stage 2, both with `kind`=0. Any other value, 7 included, gives `fault`=1 (unsupported).
- R4: For stage 1, exactly one `req_valid` pulse is issued, one cycle after the strobe is taken. Its `req_addr` is {word1[15:0], word0[31:6], 6'b0}.
- R5: A response with `rsp_err` set gives `fault`=3. A descriptor whose word0 bit 30 is clear gives `fault`=4. Either fault is reported one cycle after the response.
- R6: Descriptor word0 bit 14 picks slot 1 when set and slot 0 when clear. Slot s takes its size from word0[16s+5:16s] and its granule code from word0[16s+7:16s+6]. Its table base is {word(3+2s)[15:0], word(2+2s)[31:4], 4'b0}.
- R7: Granule decode for slot 0 and for stage 2 maps code 0 to 12 bits, 1 to 16 and 2 to 14. For slot 1 it maps code 1 to 14, 2 to 12 and 3 to 16. Any other code gives 12.
- R8: When the format flag is set, `tsz` is clamped to 16..39. The flag is descriptor word1 bit 9 for stage 1 and entry word5 bit 19 for stage 2. When the flag is clear, the raw size is passed through.
- R9: Output size code n decodes to 42 bits for n=3, to 44 bits for n=4, and to 32+2^n bits otherwise, capped at the decode of `OAS_MAX_CODE`. Stage 1 takes the code from descriptor word1[2:0]. Stage 2 takes it from entry word5[18:16], first capped at `OAS_MAX_CODE`, and uses a fixed 40 bits when the format flag is clear.
- R10: `ttb` holds only the low `oas` bits of the table base.
- R11: `level` = 4 - trunc((60 - tsz) / (granule - 3)), with division truncating toward zero, as a 4-bit two's complement value.
- R12: Stage 2 gives `fault`=2 in any of three cases. The first is a format flag set with granule code 3, or with a granule missing from `GRAN_SUPPORT` (bit0 for 4K, bit1 for 16K, bit2 for 64K). The second is a table base {word7[15:0], word6[31:4], 4'b0} at or above 2^range. The third is a computed `level` different from 3 - word5[7:6]. The granule code is word5[15:14] and the raw size is word5[5:0].
- R13: `done` is a single-cycle pulse, raised two cycles after the strobe for results that need no descriptor and four cycles after it for a decoded descriptor when the response arrives at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that takes `entry` and `unit_en` when idle |
| unit_en | input | 1 | Translation unit enabled |
| entry | input | ENTRY_BYTES*8 | Stream table entry, word i at bits [32i+31:32i] |
| req_valid | output | 1 | Descriptor fetch request pulse |
| req_addr | output | 48 | Descriptor address |
| rsp_valid | input | 1 | Descriptor response strobe |
| rsp_err | input | 1 | Descriptor fetch failed |
| rsp_data | input | ENTRY_BYTES*8 | Descriptor words |
| done | output | 1 | Result pulse |
| fault | output | 3 | 0 none, 1 unsupported, 2 bad entry, 3 fetch error, 4 bad descriptor |
| kind | output | 2 | 0 translate, 1 bypass, 2 disabled |
| stage | output | 2 | Stage number 1 or 2, 0 otherwise |
| gran_bits | output | 5 | Granule size in address bits |
| tsz | output | 6 | Input-size field after clamping |
| ttb | output | 48 | Truncated table base |
| oas | output | 8 | Output address size in bits |
| fmt64 | output | 1 | 64-bit format flag |
| level | output | 4 | Starting lookup level, two's complement |

## Verification
The bench builds the block with `OAS_MAX_CODE`=4 and `GRAN_SUPPORT`=3'b011. The 44-bit cap then applies both to a stage-1 size code of 5 and to a stage-2 code of 6, so the capping of R9 is exercised. Because the 64K granule is unsupported, a stage-2 entry that asks for it with the format flag set must fault. The same granule with the flag clear must still decode, which shows that the support check applies only when the flag is set. The directed entries also push the size field above 60 without clamping, which drives the level division negative and checks its truncation toward zero.

// File: rtl/xcd_pkg.sv
package xcd_pkg;

  localparam int AW = 48;

  localparam logic [2:0] FLT_NONE      = 3'd0;
  localparam logic [2:0] FLT_UNSUPP    = 3'd1;
  localparam logic [2:0] FLT_BAD_ENTRY = 3'd2;
  localparam logic [2:0] FLT_CTX_FETCH = 3'd3;
  localparam logic [2:0] FLT_BAD_CTX   = 3'd4;

  localparam logic [1:0] KIND_XLATE  = 2'd0;
  localparam logic [1:0] KIND_BYPASS = 2'd1;
  localparam logic [1:0] KIND_OFF    = 2'd2;

  typedef enum logic [1:0] {
    MODE_BYPASS,
    MODE_S1,
    MODE_S2,
    MODE_BAD
  } mode_e;

  // output size code to address bits
  function automatic logic [7:0] oas_from_code(input logic [2:0] code);
    case (code)
      3'd3:    oas_from_code = 8'd42;
      3'd4:    oas_from_code = 8'd44;
      default: oas_from_code = 8'd32 + (8'd1 << code);
    endcase
  endfunction

  // granule code to address bits; slot1 uses the alternate encoding
  function automatic logic [4:0] gran_from_code(input logic [1:0] code, input logic slot1);
    case (code)
      2'd1:    gran_from_code = slot1 ? 5'd14 : 5'd16;
      2'd2:    gran_from_code = slot1 ? 5'd12 : 5'd14;
      2'd3:    gran_from_code = slot1 ? 5'd16 : 5'd12;
      default: gran_from_code = 5'd12;
    endcase
  endfunction

endpackage

// File: rtl/xcd_entry_check.sv
module xcd_entry_check
  import xcd_pkg::*;
#(
  parameter int         ENTRY_BYTES  = 64,
  parameter int         OAS_MAX_CODE = 5,
  parameter logic [2:0] GRAN_SUPPORT = 3'b111
) (
  input  logic [ENTRY_BYTES*8-1:0] ent,
  output logic                     ent_valid,
  output mode_e                    mode,
  output logic [AW-1:0]            ctx_addr,
  output logic [5:0]               s2_tsz_raw,
  output logic [1:0]               s2_tg,
  output logic [1:0]               s2_sl,
  output logic                     s2_fmt64,
  output logic [7:0]               s2_range,
  output logic [AW-1:0]            s2_base,
  output logic                     s2_reject
);

  localparam logic [2:0] MAX_CODE = 3'(OAS_MAX_CODE);

  logic [31:0] w0, w1, w5, w6, w7;
  logic [2:0]  cfg;
  logic [2:0]  ps_capped;
  logic        gran_ok;
  logic        base_oor;

  assign w0 = ent[0*32 +: 32];
  assign w1 = ent[1*32 +: 32];
  assign w5 = ent[5*32 +: 32];
  assign w6 = ent[6*32 +: 32];
  assign w7 = ent[7*32 +: 32];

  assign ent_valid = w0[0];
  assign cfg       = w0[3:1];

  always_comb begin
    case (cfg)
      3'd4:    mode = MODE_BYPASS;
      3'd5:    mode = MODE_S1;
      3'd6:    mode = MODE_S2;
      default: mode = MODE_BAD;
    endcase
  end

  assign ctx_addr   = {w1[15:0], w0[31:6], 6'b0};
  assign s2_tsz_raw = w5[5:0];
  assign s2_sl      = w5[7:6];
  assign s2_tg      = w5[15:14];
  assign s2_fmt64   = w5[19];
  assign s2_base    = {w7[15:0], w6[31:4], 4'b0};

  assign ps_capped = (w5[18:16] > MAX_CODE) ? MAX_CODE : w5[18:16];
  assign s2_range  = s2_fmt64 ? oas_from_code(ps_capped) : 8'd40;

  always_comb begin
    case (s2_tg)
      2'd0:    gran_ok = GRAN_SUPPORT[0];
      2'd2:    gran_ok = GRAN_SUPPORT[1];
      2'd1:    gran_ok = GRAN_SUPPORT[2];
      default: gran_ok = 1'b0;
    endcase
    if (!s2_fmt64) gran_ok = 1'b1;
  end

  assign base_oor  = (s2_range < 8'(AW)) && ((s2_base >> s2_range) != '0);
  assign s2_reject = !gran_ok || base_oor;

endmodule

// File: rtl/xcd_size_calc.sv
module xcd_size_calc
  import xcd_pkg::*;
#(
  parameter int OAS_MAX_CODE = 5
) (
  input  logic [1:0]    tg_code,
  input  logic          slot1,
  input  logic [5:0]    tsz_raw,
  input  logic          fmt64,
  input  logic [7:0]    oas_raw,
  input  logic [AW-1:0] base_raw,
  output logic [4:0]    gran,
  output logic [5:0]    tsz,
  output logic [7:0]    oas,
  output logic [AW-1:0] base,
  output logic [3:0]    level
);

  localparam logic [7:0] OAS_CAP = oas_from_code(3'(OAS_MAX_CODE));

  logic signed [7:0] num, den, quo, lvl;

  assign gran = gran_from_code(tg_code, slot1);

  always_comb begin
    tsz = tsz_raw;
    if (fmt64) begin
      if (tsz_raw > 6'd39) tsz = 6'd39;
      if (tsz_raw < 6'd16) tsz = 6'd16;
    end
  end

  assign oas = (oas_raw > OAS_CAP) ? OAS_CAP : oas_raw;

  always_comb begin
    for (int i = 0; i < AW; i++) begin
      base[i] = base_raw[i] & (8'(i) < oas);
    end
  end

  always_comb begin
    num = 8'sd60 - $signed({2'b00, tsz});
    den = $signed({3'b000, gran}) - 8'sd3;
    quo = num / den;
    lvl = 8'sd4 - quo;
  end

  assign level = lvl[3:0];

  // R11: starting level lies within the reachable range -2..4
  always_comb begin
    a_r11_level_range: assert (lvl >= -8'sd2 && lvl <= 8'sd4);
  end

endmodule

// File: rtl/xcd_top.sv
module xcd_top
  import xcd_pkg::*;
#(
  parameter int         ENTRY_BYTES  = 64,
  parameter int         OAS_MAX_CODE = 5,
  parameter logic [2:0] GRAN_SUPPORT = 3'b111
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     unit_en,
  input  logic [ENTRY_BYTES*8-1:0] entry,
  output logic                     req_valid,
  output logic [47:0]              req_addr,
  input  logic                     rsp_valid,
  input  logic                     rsp_err,
  input  logic [ENTRY_BYTES*8-1:0] rsp_data,
  output logic                     done,
  output logic [2:0]               fault,
  output logic [1:0]               kind,
  output logic [1:0]               stage,
  output logic [4:0]               gran_bits,
  output logic [5:0]               tsz,
  output logic [47:0]              ttb,
  output logic [7:0]               oas,
  output logic                     fmt64,
  output logic [3:0]               level
);

  localparam int EW = ENTRY_BYTES * 8;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WAIT, ST_CALC} state_e;

  state_e         state;
  logic [EW-1:0]  ent_q, cd_q;
  logic           en_q;

  // entry decode
  logic           ent_valid;
  mode_e          mode;
  logic [AW-1:0]  ctx_addr;
  logic [5:0]     s2_tsz_raw;
  logic [1:0]     s2_tg, s2_sl;
  logic           s2_fmt64;
  logic [7:0]     s2_range;
  logic [AW-1:0]  s2_base;
  logic           s2_reject;

  xcd_entry_check #(
    .ENTRY_BYTES (ENTRY_BYTES),
    .OAS_MAX_CODE(OAS_MAX_CODE),
    .GRAN_SUPPORT(GRAN_SUPPORT)
  ) u_check (
    .ent       (ent_q),
    .ent_valid (ent_valid),
    .mode      (mode),
    .ctx_addr  (ctx_addr),
    .s2_tsz_raw(s2_tsz_raw),
    .s2_tg     (s2_tg),
    .s2_sl     (s2_sl),
    .s2_fmt64  (s2_fmt64),
    .s2_range  (s2_range),
    .s2_base   (s2_base),
    .s2_reject (s2_reject)
  );

  // descriptor fields
  logic [31:0]   cw0, cw1;
  logic          cd_slot1;
  logic [5:0]    cd_tsz_raw;
  logic [1:0]    cd_tg;
  logic [AW-1:0] cd_base;

  assign cw0        = cd_q[0*32 +: 32];
  assign cw1        = cd_q[1*32 +: 32];
  assign cd_slot1   = cw0[14];
  assign cd_tsz_raw = cd_slot1 ? cw0[21:16] : cw0[5:0];
  assign cd_tg      = cd_slot1 ? cw0[23:22] : cw0[7:6];
  assign cd_base    = cd_slot1 ? {cd_q[5*32 +: 16], cd_q[4*32+4 +: 28], 4'b0}
                               : {cd_q[3*32 +: 16], cd_q[2*32+4 +: 28], 4'b0};

  // shared size calculator, inputs chosen by state
  logic [1:0]    c_tg;
  logic          c_slot1, c_fmt64;
  logic [5:0]    c_tsz_raw;
  logic [7:0]    c_oas_raw;
  logic [AW-1:0] c_base_raw;
  logic [4:0]    r_gran;
  logic [5:0]    r_tsz;
  logic [7:0]    r_oas;
  logic [AW-1:0] r_base;
  logic [3:0]    r_level;

  always_comb begin
    if (state == ST_CALC) begin
      c_tg       = cd_tg;
      c_slot1    = cd_slot1;
      c_tsz_raw  = cd_tsz_raw;
      c_fmt64    = cw1[9];
      c_oas_raw  = oas_from_code(cw1[2:0]);
      c_base_raw = cd_base;
    end else begin
      c_tg       = s2_tg;
      c_slot1    = 1'b0;
      c_tsz_raw  = s2_tsz_raw;
      c_fmt64    = s2_fmt64;
      c_oas_raw  = s2_range;
      c_base_raw = s2_base;
    end
  end

  xcd_size_calc #(
    .OAS_MAX_CODE(OAS_MAX_CODE)
  ) u_calc (
    .tg_code (c_tg),
    .slot1   (c_slot1),
    .tsz_raw (c_tsz_raw),
    .fmt64   (c_fmt64),
    .oas_raw (c_oas_raw),
    .base_raw(c_base_raw),
    .gran    (r_gran),
    .tsz     (r_tsz),
    .oas     (r_oas),
    .base    (r_base),
    .level   (r_level)
  );

  logic level_match;
  assign level_match = (r_level == {2'b00, ~s2_sl});

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ent_q     <= '0;
      cd_q      <= '0;
      en_q      <= 1'b0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      done      <= 1'b0;
      fault     <= FLT_NONE;
      kind      <= KIND_XLATE;
      stage     <= 2'd0;
      gran_bits <= '0;
      tsz       <= '0;
      ttb       <= '0;
      oas       <= '0;
      fmt64     <= 1'b0;
      level     <= '0;
    end else begin
      done      <= 1'b0;
      req_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ent_q <= entry;
            en_q  <= unit_en;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          state     <= ST_IDLE;
          done      <= 1'b1;
          fault     <= FLT_NONE;
          kind      <= KIND_XLATE;
          stage     <= 2'd0;
          gran_bits <= '0;
          tsz       <= '0;
          ttb       <= '0;
          oas       <= '0;
          fmt64     <= 1'b0;
          level     <= '0;
          if (!en_q) begin
            kind <= KIND_OFF;
          end else if (!ent_valid) begin
            fault <= FLT_BAD_ENTRY;
          end else begin
            case (mode)
              MODE_BYPASS: kind <= KIND_BYPASS;
              MODE_S2: begin
                if (s2_reject || !level_match) begin
                  fault <= FLT_BAD_ENTRY;
                end else begin
                  stage     <= 2'd2;
                  gran_bits <= r_gran;
                  tsz       <= r_tsz;
                  ttb       <= r_base;
                  oas       <= r_oas;
                  fmt64     <= s2_fmt64;
                  level     <= r_level;
                end
              end
              MODE_S1: begin
                done      <= 1'b0;
                req_valid <= 1'b1;
                req_addr  <= ctx_addr;
                state     <= ST_WAIT;
              end
              default: fault <= FLT_UNSUPP;
            endcase
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err || !rsp_data[30]) begin
              state     <= ST_IDLE;
              done      <= 1'b1;
              fault     <= rsp_err ? FLT_CTX_FETCH : FLT_BAD_CTX;
              kind      <= KIND_XLATE;
              stage     <= 2'd0;
              gran_bits <= '0;
              tsz       <= '0;
              ttb       <= '0;
              oas       <= '0;
              fmt64     <= 1'b0;
              level     <= '0;
            end else begin
              cd_q  <= rsp_data;
              state <= ST_CALC;
            end
          end
        end
        ST_CALC: begin
          state     <= ST_IDLE;
          done      <= 1'b1;
          fault     <= FLT_NONE;
          kind      <= KIND_XLATE;
          stage     <= 2'd1;
          gran_bits <= r_gran;
          tsz       <= r_tsz;
          ttb       <= r_base;
          oas       <= r_oas;
          fmt64     <= cw1[9];
          level     <= r_level;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: result strobe lasts one cycle
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: request is a single pulse and never coincides with a result
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
  a_r4_req_no_done: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !done);

  // R2: faults carry no parameters
  a_r2_fault_clean: assert property (@(posedge clk) disable iff (rst)
    (done && fault != FLT_NONE) |-> (stage == 2'd0 && ttb == '0 && kind == KIND_XLATE));

  // R8: clamped size when the format flag is set
  a_r8_tsz_clamp: assert property (@(posedge clk) disable iff (rst)
    (done && stage != 2'd0 && fmt64) |-> (tsz >= 6'd16 && tsz <= 6'd39));

  // R10: no table base bit at or above the output size
  a_r10_ttb_trunc: assert property (@(posedge clk) disable iff (rst)
    (done && stage != 2'd0) |-> ((ttb >> oas) == '0));

  // R1: a disabled result never follows a request
  a_r1_off_no_req: assert property (@(posedge clk) disable iff (rst)
    (done && kind == KIND_OFF) |-> !$past(req_valid));

endmodule

// File: tb/sim_xcd_top.sv
module sim_xcd_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         start, unit_en;
  logic [511:0] entry;
  logic         req_valid;
  logic [47:0]  req_addr;
  logic         rsp_valid, rsp_err;
  logic [511:0] rsp_data;
  logic         done;
  logic [2:0]   fault;
  logic [1:0]   kind, stage;
  logic [4:0]   gran_bits;
  logic [5:0]   tsz;
  logic [47:0]  ttb;
  logic [7:0]   oas;
  logic         fmt64;
  logic [3:0]   level;

  always #5 clk = ~clk;

  xcd_top #(
    .ENTRY_BYTES (64),
    .OAS_MAX_CODE(4),
    .GRAN_SUPPORT(3'b011)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .unit_en(unit_en), .entry(entry),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .done(done), .fault(fault), .kind(kind), .stage(stage),
    .gran_bits(gran_bits), .tsz(tsz), .ttb(ttb), .oas(oas),
    .fmt64(fmt64), .level(level)
  );

  int n_run = 0;
  int n_fail = 0;

  // captured results
  int          lat, n_req;
  logic [47:0] got_addr;
  logic        pulse_ok;
  logic [2:0]  c_fault;
  logic [1:0]  c_kind, c_stage;
  logic [4:0]  c_gran;
  logic [5:0]  c_tsz;
  logic [47:0] c_ttb;
  logic [7:0]  c_oas;
  logic        c_fmt;
  logic [3:0]  c_lvl;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] pk(input logic [31:0] a, b, c, d, e, f, g, h);
    logic [511:0] v = '0;
    v[255:0] = {h, g, f, e, d, c, b, a};
    return v;
  endfunction

  task automatic run(input logic [511:0] e, input logic en, input logic err,
                     input logic [511:0] cdat);
    logic seen = 1'b0;
    n_req = 0; lat = 0; got_addr = '0; pulse_ok = 1'b0;
    @(negedge clk);
    start = 1'b1; entry = e; unit_en = en;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc < 40 && !seen; cyc++) begin
      if (done) begin
        seen = 1'b1; lat = cyc;
        c_fault = fault; c_kind = kind; c_stage = stage; c_gran = gran_bits;
        c_tsz = tsz; c_ttb = ttb; c_oas = oas; c_fmt = fmt64; c_lvl = level;
      end
      if (req_valid) begin
        n_req++; got_addr = req_addr;
        rsp_valid = 1'b1; rsp_err = err; rsp_data = cdat;
      end
      @(negedge clk);
      rsp_valid = 1'b0;
      if (seen) pulse_ok = !done;
    end
    if (!seen) chk("R13 result timeout", 64'd0, 64'd1);
  endtask

  task automatic expect_params(input string r, input logic [1:0] stg, input logic [4:0] g,
      input logic [5:0] t, input logic [47:0] b, input logic [7:0] o,
      input logic f, input logic [3:0] l);
    chk({r, " R3 fault"}, 64'(c_fault), 64'd0);
    chk({r, " R3 stage"}, 64'(c_stage), 64'(stg));
    chk({r, " R7 granule"}, 64'(c_gran), 64'(g));
    chk({r, " R8 tsz"}, 64'(c_tsz), 64'(t));
    chk({r, " R10 ttb"}, 64'(c_ttb), 64'(b));
    chk({r, " R9 oas"}, 64'(c_oas), 64'(o));
    chk({r, " R8 fmt64"}, 64'(c_fmt), 64'(f));
    chk({r, " R11 level"}, 64'(c_lvl), 64'(l));
    chk({r, " R13 pulse"}, 64'(pulse_ok), 64'd1);
  endtask

  task automatic expect_fault(input string r, input logic [2:0] f, input int lt);
    chk({r, " fault"}, 64'(c_fault), 64'(f));
    chk({r, " R2 params cleared"}, {c_ttb, c_stage, c_kind, c_oas}, 64'd0);
    chk({r, " R13 latency"}, 64'(lat), 64'(lt));
  endtask

  // scenarios
  task automatic t_reset();
    chk("R13 reset done", 64'(done), 64'd0);
    chk("R4 reset req", 64'(req_valid), 64'd0);
  endtask

  task automatic t_disabled();
    run(pk(32'h123456CB, 32'h77, 0, 0, 0, 0, 0, 0), 1'b0, 1'b0, '0);
    chk("R1 kind", 64'(c_kind), 64'd2);
    chk("R1 fault", 64'(c_fault), 64'd0);
    chk("R1 no request", 64'(n_req), 64'd0);
    chk("R13 latency", 64'(lat), 64'd2);
  endtask

  task automatic t_invalid();
    run(pk(32'hA, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, '0);
    expect_fault("R2 invalid", 3'd2, 2);
  endtask

  task automatic t_modes();
    run(pk(32'h9, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, '0);
    chk("R3 bypass kind", 64'(c_kind), 64'd1);
    chk("R3 bypass fault", 64'(c_fault), 64'd0);
    chk("R3 bypass no request", 64'(n_req), 64'd0);
    run(pk(32'h1, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, '0);
    expect_fault("R3 config0", 3'd1, 2);
    run(pk(32'hF, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, '0);
    expect_fault("R3 nested", 3'd1, 2);
  endtask

  task automatic t_s1_slot0();
    run(pk(32'h123456CB, 32'h77, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0,
        pk(32'h40000099, 32'h202, 32'hDEADBEEF, 32'hAB, 0, 0, 0, 0));
    chk("R4 one request", 64'(n_req), 64'd1);
    chk("R4 address", 64'(got_addr), 64'h0077_1234_56C0);
    chk("R13 ctx latency", 64'(lat), 64'd4);
    expect_params("R6 slot0", 2'd1, 5'd14, 6'd25, 48'hB_DEAD_BEE0, 8'd36, 1'b1, 4'd1);
  endtask

  task automatic t_s1_slot1();
    run(pk(32'h0000000B, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0,
        pk(32'h40CA4072, 32'h205, 0, 0, 32'h11112225, 32'hFFFF, 0, 0));
    expect_params("R6 slot1", 2'd1, 5'd16, 6'd16, 48'h0FFF_1111_2220, 8'd44, 1'b1, 4'd1);
    run(pk(32'h0000000B, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0,
        pk(32'h40944000, 32'h201, 0, 0, 0, 0, 0, 0));
    expect_params("R7 slot1 code2", 2'd1, 5'd12, 6'd20, 48'h0, 8'd34, 1'b1, 4'd0);
  endtask

  task automatic t_s1_noclamp();
    run(pk(32'h0000000B, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0,
        pk(32'h4000007E, 32'h3, 32'h10, 0, 0, 0, 0, 0));
    expect_params("R11 negative numerator", 2'd1, 5'd16, 6'd62, 48'h10, 8'd42, 1'b0, 4'd4);
  endtask

  task automatic t_s1_faults();
    run(pk(32'h0000000B, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b1,
        pk(32'h40000099, 32'h202, 0, 0, 0, 0, 0, 0));
    expect_fault("R5 fetch error", 3'd3, 3);
    run(pk(32'h0000000B, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0,
        pk(32'h00000099, 32'h202, 0, 0, 0, 0, 0, 0));
    expect_fault("R5 bad descriptor", 3'd4, 3);
  endtask

  task automatic t_s2();
    run(pk(32'hD, 0, 0, 0, 0, 32'h000A009E, 32'h12345678, 32'h5), 1'b1, 1'b0, '0);
    chk("R12 no request", 64'(n_req), 64'd0);
    chk("R13 s2 latency", 64'(lat), 64'd2);
    expect_params("R12 s2 ok", 2'd2, 5'd12, 6'd30, 48'h5_1234_5670, 8'd36, 1'b1, 4'd1);
    run(pk(32'hD, 0, 0, 0, 0, 32'h0007402D, 32'hFFFFFFF0, 32'hFF), 1'b1, 1'b0, '0);
    expect_params("R9 s2 fixed 40", 2'd2, 5'd16, 6'd45, 48'hFF_FFFF_FFF0, 8'd40, 1'b0, 4'd3);
    run(pk(32'hD, 0, 0, 0, 0, 32'h000E8094, 0, 0), 1'b1, 1'b0, '0);
    expect_params("R9 s2 code cap", 2'd2, 5'd14, 6'd20, 48'h0, 8'd44, 1'b1, 4'd1);
    run(pk(32'hD, 0, 0, 0, 0, 32'h000800C5, 0, 0), 1'b1, 1'b0, '0);
    expect_params("R8 s2 clamp low", 2'd2, 5'd12, 6'd16, 48'h0, 8'd33, 1'b1, 4'd0);
  endtask

  task automatic t_s2_faults();
    run(pk(32'hD, 0, 0, 0, 0, 32'h000A005E, 32'h12345678, 32'h5), 1'b1, 1'b0, '0);
    expect_fault("R12 level mismatch", 3'd2, 2);
    run(pk(32'hD, 0, 0, 0, 0, 32'h000A409E, 0, 0), 1'b1, 1'b0, '0);
    expect_fault("R12 granule unsupported", 3'd2, 2);
    run(pk(32'hD, 0, 0, 0, 0, 32'h000A009E, 32'h12345678, 32'h10), 1'b1, 1'b0, '0);
    expect_fault("R12 base out of range", 3'd2, 2);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL R13 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; unit_en = 1'b0; entry = '0;
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_invalid();
    t_modes();
    t_s1_slot0();
    t_s1_slot1();
    t_s1_noclamp();
    t_s1_faults();
    t_s2();
    t_s2_faults();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule